// File: doc/BRIEF.md
# Three-Wire Result Read and Timebase Load Port

This block is the host-facing serial port of a dual-slope converter controller. It works entirely in the system clock domain. The host's serial clock, its two active-low strobes and its data-in line are sampled there, and their edges are found there. When the read strobe goes low, the block takes a snapshot of the latest conversion result: an overrange flag, a polarity flag and a 16-bit magnitude. It then shifts that snapshot out on a data pin, which is released whenever the read strobe is high.

While the load strobe is low, the block collects an 8-bit timebase value from the data-in line. It hands that value to the phase sequencer when the strobe is released. If the host pulses the load strobe without clocking any bits, the level on data-in picks one of two default timebase values instead. The phase sequencer supplies each finished result with a one-cycle valid pulse, and it consumes the committed timebase value.

Top module: `tw_serial_port`

## Requirements
- R1: After reset, `sdo_en` and `tb_commit` are 0 and `tb_value` equals `DEF_LOAD` (default 8'h00).
- R2: A falling edge on `rd_n` captures the most recent result into the output shifter. If `res_valid` is high in the capture cycle, the fresh result is the one taken.
- R3: The frame is 18 bits: first the overrange bit, then the polarity bit (1 = positive input), then the magnitude from bit 15 down to bit 0. After the last bit the output reads 0.
- R4: The overrange bit is on `sdo`, with `sdo_en` high, before any serial clock edge once `rd_n` is low.
- R5: The output moves to the next bit only on a falling edge of `sclk` while `rd_n` is low. A rising edge leaves it unchanged.
- R6: `sdo_en` is high exactly while the sampled `rd_n` is low, and `sdo` is high-impedance when it is low. Raising `rd_n` ends the transfer at any bit.
- R7: While `ld_n` is low, each rising `sclk` edge shifts `sdi` into an 8-bit register, most significant bit first.
- R8: When `ld_n` rises after one or more clocked bits, the collected value appears on `tb_value`, and `tb_commit` pulses for exactly one cycle. `tb_value` changes at no other time.
- R9: A low pulse on `ld_n` with no `sclk` rising edge commits 8'h00 (65536-count phase) if `sdi` is high, and 8'h80 (32768-count phase) if it is low.
- R10: The held result changes only on a `res_valid` pulse. A result arriving during a transfer does not disturb the bits being shifted out.
- R11: Every host input passes through two synchroniser flops. An edge on a pin takes effect at the third rising `clk` edge after it. `sclk` high and low times must each exceed four `clk` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe from host |
| ld_n | input | 1 | Active-low timebase load strobe from host |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data in |
| res_valid | input | 1 | One-cycle pulse: a new conversion result is present |
| res_ovr | input | 1 | Overrange flag of the new result |
| res_pol | input | 1 | Polarity of the new result, 1 = positive |
| res_mag | input | 16 | Magnitude of the new result |
| sdo | output | 1 | Serial data out, high-impedance when not enabled |
| sdo_en | output | 1 | Output-enable of `sdo` |
| tb_value | output | 8 | Committed timebase value for the phase sequencer |
| tb_commit | output | 1 | One-cycle pulse when `tb_value` is written |

## Verification
The bench aims at the timing corners. It checks that the first bit is present before any clock: a design that waited for an `sclk` edge would lose the overrange bit. It checks a read that is cut off mid-frame: a design that missed this would keep driving `sdo` or fail to restart on the next strobe. It checks that a rising `sclk` does not advance the output: a design that shifted on both edges would skip every other bit. It posts a fresh result in the middle of a transfer: a design without a separate held register would corrupt the frame in progress. Both strobe-only load pulses are run, so a design with the two default values swapped commits the wrong timebase.

// File: rtl/tw_pkg.sv
package tw_pkg;
   // bit positions inside the synchronised host input vector
   localparam int IDX_RD   = 0;
   localparam int IDX_LD   = 1;
   localparam int IDX_SCLK = 2;
   localparam int IDX_SDI  = 3;
   localparam int N_HOST   = 4;
   // idle levels loaded into the synchroniser on reset: strobes high
   localparam logic [N_HOST-1:0] HOST_IDLE = 4'b0011;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   localparam int DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {DEPTH{RST_VAL}};
      else        chain <= {chain[DEPTH-2:0], d};
   end

   for (genvar b = 0; b < W; b++) begin : g_edge
      assign q[b]    = chain[STAGES-1][b];
      assign rise[b] =  chain[STAGES-1][b] & ~chain[STAGES][b];
      assign fall[b] = ~chain[STAGES-1][b] &  chain[STAGES][b];
   end
endmodule

// File: rtl/tw_rd_shift.sv
module tw_rd_shift #(
   parameter int MAG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_fall,
   input  logic             rd_rise,
   input  logic             sclk_fall,
   input  logic             res_valid,
   input  logic             res_ovr,
   input  logic             res_pol,
   input  logic [MAG_W-1:0] res_mag,
   output logic             sdo_bit,
   output logic             sdo_en
);
   localparam int FRAME_W = MAG_W + 2;

   if (MAG_W < 1) begin : g_bad_mag
      $error("tw_rd_shift: MAG_W must be positive");
   end

   logic [FRAME_W-1:0] held;
   logic [FRAME_W-1:0] fresh;
   logic [FRAME_W-1:0] snap;
   logic [FRAME_W-1:0] shreg;
   logic               oe;

   assign fresh = {res_ovr, res_pol, res_mag};
   assign snap  = res_valid ? fresh : held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= '0;
         shreg <= '0;
         oe    <= 1'b0;
      end else begin
         if (res_valid) held <= fresh;
         if (rd_fall) begin
            shreg <= snap;
            oe    <= 1'b1;
         end else if (rd_rise) begin
            oe    <= 1'b0;
         end else if (oe && sclk_fall) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
         end
      end
   end

   assign sdo_bit = shreg[FRAME_W-1];
   assign sdo_en  = oe;

   // R10
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(held));
   // R5
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !rd_fall) |=> $stable(shreg));
   // R6
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rise |=> !oe);
   // R2
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fall |=> (oe && shreg == $past(snap)));
endmodule

// File: rtl/tw_ld_shift.sv
module tw_ld_shift #(
   parameter int                LOAD_W   = 8,
   parameter logic [LOAD_W-1:0] DEF_LOAD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_low,
   input  logic              ld_fall,
   input  logic              ld_rise,
   input  logic              sclk_rise,
   input  logic              sdi,
   output logic [LOAD_W-1:0] tb_value,
   output logic              tb_commit
);
   localparam logic [LOAD_W-1:0] PICK_LONG  = '0;
   localparam logic [LOAD_W-1:0] PICK_SHORT = {1'b1, {(LOAD_W-1){1'b0}}};

   if (LOAD_W < 2) begin : g_bad_load
      $error("tw_ld_shift: LOAD_W must be at least 2");
   end

   logic [LOAD_W-1:0] acc;
   logic              seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         seen      <= 1'b0;
         tb_value  <= DEF_LOAD;
         tb_commit <= 1'b0;
      end else begin
         if (ld_fall) begin
            acc  <= '0;
            seen <= 1'b0;
         end else if (ld_low && sclk_rise) begin
            acc  <= {acc[LOAD_W-2:0], sdi};
            seen <= 1'b1;
         end
         tb_commit <= ld_rise;
         if (ld_rise) tb_value <= seen ? acc : (sdi ? PICK_LONG : PICK_SHORT);
      end
   end

   // R8
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_commit |=> !tb_commit);
   // R8
   value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> $stable(tb_value));
   // R9
   default_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && !seen && sdi) |=> (tb_value == PICK_LONG));
   // R9
   default_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && !seen && !sdi) |=> (tb_value == PICK_SHORT));
endmodule

// File: rtl/tw_serial_port.sv
module tw_serial_port #(
   parameter int                MAG_W    = 16,
   parameter int                LOAD_W   = 8,
   parameter int                STAGES   = 2,
   parameter logic [LOAD_W-1:0] DEF_LOAD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              ld_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              res_valid,
   input  logic              res_ovr,
   input  logic              res_pol,
   input  logic [MAG_W-1:0]  res_mag,
   output logic              sdo,
   output logic              sdo_en,
   output logic [LOAD_W-1:0] tb_value,
   output logic              tb_commit
);
   import tw_pkg::*;

   logic [N_HOST-1:0] host_raw, host_q, host_rise, host_fall;
   logic              sdo_bit;

   assign host_raw[IDX_RD]   = rd_n;
   assign host_raw[IDX_LD]   = ld_n;
   assign host_raw[IDX_SCLK] = sclk;
   assign host_raw[IDX_SDI]  = sdi;

   tw_sync #(.W(N_HOST), .STAGES(STAGES), .RST_VAL(HOST_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (host_raw),
      .q    (host_q),
      .rise (host_rise),
      .fall (host_fall)
   );

   tw_rd_shift #(.MAG_W(MAG_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_fall  (host_fall[IDX_RD]),
      .rd_rise  (host_rise[IDX_RD]),
      .sclk_fall(host_fall[IDX_SCLK]),
      .res_valid(res_valid),
      .res_ovr  (res_ovr),
      .res_pol  (res_pol),
      .res_mag  (res_mag),
      .sdo_bit  (sdo_bit),
      .sdo_en   (sdo_en)
   );

   tw_ld_shift #(.LOAD_W(LOAD_W), .DEF_LOAD(DEF_LOAD)) u_ld (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_low   (~host_q[IDX_LD]),
      .ld_fall  (host_fall[IDX_LD]),
      .ld_rise  (host_rise[IDX_LD]),
      .sclk_rise(host_rise[IDX_SCLK]),
      .sdi      (host_q[IDX_SDI]),
      .tb_value (tb_value),
      .tb_commit(tb_commit)
   );

   assign sdo = sdo_en ? sdo_bit : 1'bz;

   // R6
   en_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_q[IDX_RD]) |=> sdo_en);
endmodule

// File: tb/sim_tw_serial_port.sv
module sim_tw_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_n = 1'b1, ld_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic        res_valid = 1'b0, res_ovr = 1'b0, res_pol = 1'b0;
   logic [15:0] res_mag = '0;
   wire         sdo;
   logic        sdo_en, tb_commit;
   logic [7:0]  tb_value;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tw_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .ld_n(ld_n), .sclk(sclk), .sdi(sdi),
      .res_valid(res_valid), .res_ovr(res_ovr), .res_pol(res_pol), .res_mag(res_mag),
      .sdo(sdo), .sdo_en(sdo_en), .tb_value(tb_value), .tb_commit(tb_commit)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // inputs act two edges after being sampled (R11)
   logic [3:0] h1 = 4'b0011, h2 = 4'b0011, h3 = 4'b0011, h4 = 4'b0011;
   bit         m_q[$];
   logic [17:0] m_held = '0;
   bit          m_en = 0, m_commit = 0;
   logic [7:0]  m_tb = 8'h00, m_acc = '0;
   int          m_cnt = 0;

   always @(posedge clk) begin
      logic [3:0]  cur, old;
      logic [17:0] word;
      if (rst_n) begin
         h4 = h3; h3 = h2; h2 = h1; h1 = {sdi, sclk, ld_n, rd_n};
         cur = h3; old = h4;
         m_commit = 0;
         if (old[0] && !cur[0]) begin
            word = res_valid ? {res_ovr, res_pol, res_mag} : m_held;
            m_q.delete();
            for (int i = 17; i >= 0; i--) m_q.push_back(word[i]);
            m_en = 1;
         end else if (!old[0] && cur[0]) begin
            m_en = 0;
         end else if (m_en && old[2] && !cur[2]) begin
            if (m_q.size() > 0) void'(m_q.pop_front());
         end
         if (res_valid) m_held = {res_ovr, res_pol, res_mag};
         if (old[1] && !cur[1]) begin
            m_acc = 0; m_cnt = 0;
         end else if (!cur[1] && !old[2] && cur[2]) begin
            m_acc = {m_acc[6:0], cur[3]}; m_cnt++;
         end
         if (!old[1] && cur[1]) begin
            m_tb = (m_cnt > 0) ? m_acc : (cur[3] ? 8'h00 : 8'h80);
            m_commit = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(sdo_en == m_en, "R6 enable", {31'd0, sdo_en}, {31'd0, m_en});
         if (m_en) check(sdo == ((m_q.size() > 0) ? m_q[0] : 1'b0), "R3 data bit",
                         {31'd0, sdo}, {31'd0, (m_q.size() > 0) ? m_q[0] : 1'b0});
         check(tb_value == m_tb, "R8 value", {24'd0, tb_value}, {24'd0, m_tb});
         check(tb_commit == m_commit, "R8 commit", {31'd0, tb_commit}, {31'd0, m_commit});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic post_result(input logic o, input logic p, input logic [15:0] m);
      @(negedge clk);
      res_ovr = o; res_pol = p; res_mag = m; res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic sclk_pulse();
      sclk = 1'b1; tick(6);
      sclk = 1'b0; tick(6);
   endtask

   task automatic read_frame(input int nbits, input int mid_post, output logic [17:0] got);
      got = '0;
      rd_n = 1'b0; tick(6);
      for (int i = 0; i < nbits; i++) begin
         got = {got[16:0], sdo};
         if (i == 0) begin
            sclk = 1'b1; tick(6);
            // R5: a rising edge alone must not advance the output
            check(sdo == got[0], "R5 rising edge hold", {31'd0, sdo}, {31'd0, got[0]});
            sclk = 1'b0; tick(6);
         end else if (i < nbits - 1) begin
            sclk_pulse();
         end
         if (i == mid_post) post_result(1'b0, 1'b1, 16'h1234);
      end
      rd_n = 1'b1; tick(6);
   endtask

   task automatic load_byte(input logic [7:0] v);
      ld_n = 1'b0; tick(6);
      for (int i = 7; i >= 0; i--) begin
         sdi = v[i]; tick(2);
         sclk_pulse();
      end
      ld_n = 1'b1; tick(6);
   endtask

   task automatic load_pulse(input logic level);
      sdi = level; tick(4);
      ld_n = 1'b0; tick(4);
      ld_n = 1'b1; tick(6);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [17:0] got;
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(sdo_en == 1'b0, "R1 reset enable", {31'd0, sdo_en}, 32'd0);
      check(tb_value == 8'h00, "R1 reset value", {24'd0, tb_value}, 32'h00);
      check(tb_commit == 1'b0, "R1 reset commit", {31'd0, tb_commit}, 32'd0);

      post_result(1'b1, 1'b0, 16'hA5C3);
      tick(2);
      // R11: enable rises on the third clock edge after the strobe falls
      rd_n = 1'b0; tick(2);
      check(sdo_en == 1'b0, "R11 latency early", {31'd0, sdo_en}, 32'd0);
      tick(1);
      check(sdo_en == 1'b1, "R11 latency on time", {31'd0, sdo_en}, 32'd1);
      // R4: overrange bit present before any serial clock
      check(sdo == 1'b1, "R4 first bit", {31'd0, sdo}, 32'd1);
      rd_n = 1'b1; tick(6);
      // R6: released after abort
      check(sdo_en == 1'b0, "R6 released", {31'd0, sdo_en}, 32'd0);

      // R2 R3: full frame
      read_frame(18, -1, got);
      check(got == {1'b1, 1'b0, 16'hA5C3}, "R3 frame order", {14'd0, got}, {14'd0, 1'b1, 1'b0, 16'hA5C3});

      // R6: abort after 5 bits, then full reread restarts from the top
      read_frame(5, -1, got);
      check(got[4:0] == 5'b10101, "R6 partial frame", {27'd0, got[4:0]}, 32'b10101);
      post_result(1'b0, 1'b0, 16'hFFFF);
      read_frame(18, -1, got);
      check(got == {2'b00, 16'hFFFF}, "R2 newest result", {14'd0, got}, {14'd0, 2'b00, 16'hFFFF});

      // R10: result arriving mid-transfer leaves the frame intact
      read_frame(18, 6, got);
      check(got == {2'b00, 16'hFFFF}, "R10 frame undisturbed", {14'd0, got}, {14'd0, 2'b00, 16'hFFFF});
      read_frame(18, -1, got);
      check(got == {2'b01, 16'h1234}, "R10 new result held", {14'd0, got}, {14'd0, 2'b01, 16'h1234});

      // R7 R8: clocked load
      load_byte(8'hA5);
      check(tb_value == 8'hA5, "R7 loaded byte", {24'd0, tb_value}, 32'hA5);
      load_byte(8'h3C);
      check(tb_value == 8'h3C, "R8 reload byte", {24'd0, tb_value}, 32'h3C);

      // R9: strobe-only defaults
      load_pulse(1'b0);
      check(tb_value == 8'h80, "R9 default short", {24'd0, tb_value}, 32'h80);
      load_pulse(1'b1);
      check(tb_value == 8'h00, "R9 default long", {24'd0, tb_value}, 32'h00);

      // R8: serial clocks with load idle do not change the value
      sdi = 1'b1; sclk_pulse(); sclk_pulse();
      check(tb_value == 8'h00, "R8 idle clocks", {24'd0, tb_value}, 32'h00);

      tick(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule